// File: doc/BRIEF.md
# GCM Counter Sequencer with Key Freshness Watchdog

This block produces the 128-bit counter blocks that feed an AES-GCM keystream engine working on a framed payload stream. Software writes a 256-bit key and a 96-bit initialisation vector into staging registers. The staged pair becomes the working pair at the next frame boundary, and the old working pair stays in use until then. Each counter block joins the 96-bit IV field to a 32-bit block count. The IV field steps by one at every frame boundary. The count restarts at 1 at every frame boundary and steps by one for each payload block.

A freshness watchdog counts a prescaled tick while a key is in use. If software does not supply a new key and IV before the count reaches a programmable limit, the block squelches traffic in both directions. That squelch holds until a new pair is committed. Traffic is also squelched from reset until the first key is committed, so line data is never passed in clear.

Top module: `gcm_ctr_seq`

## Requirements
- R1: While reset is asserted and after it is released, the counter block, the valid strobe and the working key read zero, and both squelch outputs read 1.
- R2: A block strobe in cycle N makes the valid output high in cycle N+1, carrying the counter block. The IV field sits in bits 127:32 and the count sits in bits 31:0. With no block strobe, the valid output is low in the next cycle.
- R3: A block strobed in the same cycle as a frame start carries count 1. Each later block in that frame carries a count one higher than the block before it (modulo 2^32).
- R4: At a frame start that commits no new key, the IV field becomes the previous IV plus 1 (modulo 2^96). At a frame start that commits a new key, the IV field is the loaded IV unchanged.
- R5: A load strobe stages a key and an IV. The staged pair becomes the working key and IV at the first frame start in a later cycle than the load. Until then the working key and the IV field keep their old values. A second load before that frame start replaces the first one.
- R6: From reset until the first commit, both squelch outputs are 1 and no counter block is marked valid.
- R7: After a commit, the watchdog counts the cycles in which the tick input is high. The cycle after the tick that brings the count to the threshold, both squelch outputs go to 1 and counter blocks stop being marked valid. This state holds regardless of further ticks.
- R8: A commit clears the watchdog count and the squelch state. From that commit, a full threshold of fresh ticks is needed before the squelch asserts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Stage key_i and iv_i this cycle |
| key_i | input | 256 | Key to stage |
| iv_i | input | 96 | IV to stage |
| frame_start_i | input | 1 | Transport frame boundary |
| blk_valid_i | input | 1 | One 128-bit payload block this cycle |
| tick_i | input | 1 | Prescaled watchdog tick |
| thresh_i | input | 32 | Watchdog tick limit |
| ctr_blk_o | output | 128 | Counter block {IV field, count} |
| ctr_vld_o | output | 1 | Counter block valid |
| key_o | output | 256 | Working key |
| squelch_tx_o | output | 1 | Squelch transmit traffic |
| squelch_rx_o | output | 1 | Squelch receive traffic |

## Verification
Suppose the IV or the count register goes wrong. The fault shows in the counter block one cycle after the next block strobe, so the bench checks the exact block value on every strobe, within a frame and across frame boundaries. A staged pair that commits at the wrong time shows up at the first frame start after the load, as a wrong working key or a wrong IV field. A watchdog fault shows as a squelch output that asserts one tick early, one tick late, or drops without a commit. The bench therefore counts ticks one at a time around the threshold.

// File: rtl/gcm_ctr_pkg.sv
package gcm_ctr_pkg;
  parameter int unsigned KEY_W_D = 256;
  parameter int unsigned IV_W_D  = 96;
  parameter int unsigned CNT_W_D = 32;
  parameter int unsigned THR_W_D = 32;
endpackage

// File: rtl/key_iv_stage.sv
module key_iv_stage #(
  parameter int unsigned KEY_W = gcm_ctr_pkg::KEY_W_D,
  parameter int unsigned IV_W  = gcm_ctr_pkg::IV_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [IV_W-1:0]  iv_i,
  input  logic             frame_start_i,
  output logic             commit_o,
  output logic [IV_W-1:0]  new_iv_o,
  output logic [KEY_W-1:0] key_o,
  output logic             keyed_o
);
  logic             pend_q, pend_n;
  logic [KEY_W-1:0] pkey_q, pkey_n, wkey_q, wkey_n;
  logic [IV_W-1:0]  piv_q, piv_n;
  logic             keyed_q, keyed_n;

  assign commit_o = frame_start_i & pend_q;
  assign new_iv_o = piv_q;
  assign key_o    = wkey_q;
  assign keyed_o  = keyed_q;

  always_comb begin
    pend_n  = load_i | (pend_q & ~frame_start_i);
    pkey_n  = load_i ? key_i : pkey_q;
    piv_n   = load_i ? iv_i  : piv_q;
    wkey_n  = commit_o ? pkey_q : wkey_q;
    keyed_n = keyed_q | commit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pkey_q  <= '0;
      piv_q   <= '0;
      wkey_q  <= '0;
      keyed_q <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      pkey_q  <= pkey_n;
      piv_q   <= piv_n;
      wkey_q  <= wkey_n;
      keyed_q <= keyed_n;
    end
  end

  // R5: working key changes only through a commit
  a_r5_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |=> $stable(key_o));
  // R6: keyed flag only rises on a commit and never falls
  a_r6_keyed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    keyed_q |=> keyed_q);
endmodule

// File: rtl/fresh_wdog.sv
module fresh_wdog #(
  parameter int unsigned THR_W = gcm_ctr_pkg::THR_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             armed_i,
  input  logic             clear_i,
  output logic             stale_o
);
  logic [THR_W-1:0] cnt_q, cnt_n;
  logic [THR_W:0]   cnt_inc;
  logic             stale_q, stale_n;
  logic             cnt_en;

  assign stale_o = stale_q;
  assign cnt_inc = {1'b0, cnt_q} + {{THR_W{1'b0}}, 1'b1};
  assign cnt_en  = armed_i & tick_i & ~stale_q;

  always_comb begin
    cnt_n   = cnt_q;
    stale_n = stale_q;
    if (clear_i) begin
      cnt_n   = '0;
      stale_n = 1'b0;
    end else if (cnt_en) begin
      cnt_n = cnt_inc[THR_W-1:0];
      if (cnt_inc >= {1'b0, thresh_i}) stale_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      stale_q <= stale_n;
    end
  end

  // R7: stale only rises after a tick
  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_q) |-> $past(tick_i));
  // R7: stale is sticky until a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_q && !clear_i) |=> stale_q);
  // R8: a clear resets count and stale
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0 && !stale_q));
endmodule

// File: rtl/ctr_gen.sv
module ctr_gen #(
  parameter int unsigned IV_W  = gcm_ctr_pkg::IV_W_D,
  parameter int unsigned CNT_W = gcm_ctr_pkg::CNT_W_D,
  localparam int unsigned BLK_W = IV_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             blk_valid_i,
  input  logic             commit_i,
  input  logic [IV_W-1:0]  new_iv_i,
  input  logic             gate_i,
  output logic [BLK_W-1:0] blk_o,
  output logic             vld_o
);
  logic [IV_W-1:0]  iv_q, iv_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_eff;
  logic [BLK_W-1:0] blk_q, blk_n;
  logic             vld_q, vld_n;

  assign blk_o = blk_q;
  assign vld_o = vld_q;

  always_comb begin
    iv_n    = iv_q;
    cnt_eff = cnt_q;
    if (frame_start_i) begin
      iv_n    = commit_i ? new_iv_i : iv_q + {{(IV_W-1){1'b0}}, 1'b1};
      cnt_eff = {{(CNT_W-1){1'b0}}, 1'b1};
    end
    cnt_n = blk_valid_i ? cnt_eff + {{(CNT_W-1){1'b0}}, 1'b1} : cnt_eff;
    blk_n = blk_valid_i ? {iv_n, cnt_eff} : blk_q;
    vld_n = blk_valid_i & ~gate_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q  <= '0;
      cnt_q <= '0;
      blk_q <= '0;
      vld_q <= 1'b0;
    end else begin
      iv_q  <= iv_n;
      cnt_q <= cnt_n;
      blk_q <= blk_n;
      vld_q <= vld_n;
    end
  end

  // R2: valid follows a block strobe by one cycle
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(blk_valid_i));
  // R3: block at a frame start carries count 1
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && blk_valid_i) |=> blk_q[CNT_W-1:0] == {{(CNT_W-1){1'b0}}, 1'b1});
  // R4: IV steps by one at a frame start without commit
  a_r4_iv_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !commit_i) |=> iv_q == $past(iv_q) + {{(IV_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/gcm_ctr_seq.sv
module gcm_ctr_seq #(
  parameter int unsigned KEY_W = gcm_ctr_pkg::KEY_W_D,
  parameter int unsigned IV_W  = gcm_ctr_pkg::IV_W_D,
  parameter int unsigned CNT_W = gcm_ctr_pkg::CNT_W_D,
  parameter int unsigned THR_W = gcm_ctr_pkg::THR_W_D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [KEY_W-1:0]      key_i,
  input  logic [IV_W-1:0]       iv_i,
  input  logic                  frame_start_i,
  input  logic                  blk_valid_i,
  input  logic                  tick_i,
  input  logic [THR_W-1:0]      thresh_i,
  output logic [IV_W+CNT_W-1:0] ctr_blk_o,
  output logic                  ctr_vld_o,
  output logic [KEY_W-1:0]      key_o,
  output logic                  squelch_tx_o,
  output logic                  squelch_rx_o
);
  logic            commit, keyed, stale, squelch, gate;
  logic [IV_W-1:0] new_iv;

  key_iv_stage #(.KEY_W(KEY_W), .IV_W(IV_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .iv_i(iv_i),
    .frame_start_i(frame_start_i), .commit_o(commit), .new_iv_o(new_iv),
    .key_o(key_o), .keyed_o(keyed));

  fresh_wdog #(.THR_W(THR_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .thresh_i(thresh_i),
    .armed_i(keyed), .clear_i(commit), .stale_o(stale));

  assign squelch      = ~keyed | stale;
  assign gate         = squelch & ~commit;
  assign squelch_tx_o = squelch;
  assign squelch_rx_o = squelch;

  ctr_gen #(.IV_W(IV_W), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .blk_valid_i(blk_valid_i), .commit_i(commit), .new_iv_i(new_iv),
    .gate_i(gate), .blk_o(ctr_blk_o), .vld_o(ctr_vld_o));

  // R6: no valid block before a key has been committed
  a_r6_no_clear_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_vld_o |-> keyed);
  // R1: unkeyed state always squelches
  a_r1_unkeyed_squelch: assert property (@(posedge clk) disable iff (!rst_n)
    !keyed |-> (squelch_tx_o && squelch_rx_o));
endmodule

// File: tb/gcm_ctr_seq_tb.sv
module gcm_ctr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n;
  logic         load_i, frame_start_i, blk_valid_i, tick_i;
  logic [255:0] key_i;
  logic [95:0]  iv_i;
  logic [31:0]  thresh_i;
  logic [127:0] ctr_blk_o;
  logic         ctr_vld_o, squelch_tx_o, squelch_rx_o;
  logic [255:0] key_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gcm_ctr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .iv_i(iv_i),
    .frame_start_i(frame_start_i), .blk_valid_i(blk_valid_i), .tick_i(tick_i),
    .thresh_i(thresh_i), .ctr_blk_o(ctr_blk_o), .ctr_vld_o(ctr_vld_o),
    .key_o(key_o), .squelch_tx_o(squelch_tx_o), .squelch_rx_o(squelch_rx_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [255:0] K1 = {8{32'h1111_0001}};
  localparam logic [255:0] K2 = {8{32'h2222_0002}};
  localparam logic [255:0] K3 = {8{32'h3333_0003}};
  localparam logic [255:0] K4 = {8{32'h4444_0004}};
  localparam logic [95:0]  V1 = 96'h0A0A_0000_0000_0000_0000_0001;
  localparam logic [95:0]  V2 = 96'h0B0B_0000_1234_5678_9ABC_0000;
  localparam logic [95:0]  V3 = 96'h0C0C_FFFF_0000_0000_0000_FFFF;
  localparam logic [95:0]  V4 = 96'h0D0D_0000_0000_0000_0000_0040;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit fs, input bit bv, input bit ld, input bit tk,
                       input logic [255:0] k, input logic [95:0] v);
    frame_start_i = fs; blk_valid_i = bv; load_i = ld; tick_i = tk;
    key_i = k; iv_i = v;
    @(negedge clk);
    frame_start_i = 0; blk_valid_i = 0; load_i = 0; tick_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 blk", ctr_blk_o, 0);
    chk("R1 vld", ctr_vld_o, 0);
    chk("R1 key", key_o, 0);
    chk("R1 squelch", {squelch_tx_o, squelch_rx_o}, 2'b11);
  endtask

  task automatic t_no_key;
    drive(1, 1, 0, 0, 0, 0);
    chk("R6 no valid before key", ctr_vld_o, 0);
    chk("R6 squelch before key", {squelch_tx_o, squelch_rx_o}, 2'b11);
  endtask

  task automatic t_stage_commit;
    drive(0, 0, 1, 0, K1, V1);
    chk("R5 key held after load", key_o, 0);
    chk("R6 still squelched", squelch_tx_o, 1);
    drive(0, 0, 1, 0, K2, V2);
    drive(1, 1, 0, 0, 0, 0);
    chk("R5 second load wins key", key_o, K2);
    chk("R4 first frame uses loaded IV", ctr_blk_o, {V2, 32'd1});
    chk("R2 vld after block", ctr_vld_o, 1);
    chk("R6 squelch released", {squelch_tx_o, squelch_rx_o}, 2'b00);
  endtask

  task automatic t_blocks;
    for (int i = 2; i <= 4; i++) begin
      drive(0, 1, 0, 0, 0, 0);
      chk("R3 count steps", ctr_blk_o, {V2, 32'(i)});
    end
    drive(0, 0, 0, 0, 0, 0);
    chk("R2 no vld without block", ctr_vld_o, 0);
    drive(0, 1, 0, 0, 0, 0);
    chk("R3 count after gap", ctr_blk_o, {V2, 32'd5});
  endtask

  task automatic t_frames;
    drive(1, 1, 0, 0, 0, 0);
    chk("R4 IV plus one", ctr_blk_o, {V2 + 96'd1, 32'd1});
    drive(1, 0, 0, 0, 0, 0);
    chk("R2 no vld on bare frame start", ctr_vld_o, 0);
    drive(0, 1, 0, 0, 0, 0);
    chk("R3 restart after bare frame start", ctr_blk_o, {V2 + 96'd2, 32'd1});
  endtask

  task automatic t_same_cycle_load;
    drive(1, 1, 1, 0, K3, V3);
    chk("R5 load same cycle not applied IV", ctr_blk_o, {V2 + 96'd3, 32'd1});
    chk("R5 load same cycle not applied key", key_o, K2);
    drive(1, 1, 0, 0, 0, 0);
    chk("R5 applied next frame IV", ctr_blk_o, {V3, 32'd1});
    chk("R5 applied next frame key", key_o, K3);
  endtask

  task automatic t_watchdog;
    drive(0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R7 no squelch below threshold", {squelch_tx_o, squelch_rx_o}, 2'b00);
    drive(0, 0, 0, 1, 0, 0);
    chk("R7 squelch at threshold", {squelch_tx_o, squelch_rx_o}, 2'b11);
    drive(0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R7 squelch sticky", squelch_rx_o, 1);
    drive(0, 1, 0, 0, 0, 0);
    chk("R7 no valid when stale", ctr_vld_o, 0);
  endtask

  task automatic t_reload;
    drive(0, 0, 1, 0, K4, V4);
    chk("R7 load alone keeps squelch", squelch_tx_o, 1);
    drive(1, 1, 0, 0, 0, 0);
    chk("R8 commit clears squelch", {squelch_tx_o, squelch_rx_o}, 2'b00);
    chk("R8 valid after commit", ctr_vld_o, 1);
    chk("R8 block after commit", ctr_blk_o, {V4, 32'd1});
    drive(0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R8 count restarted", squelch_tx_o, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R8 full threshold again", squelch_tx_o, 1);
  endtask

  task automatic t_wrap;
    drive(0, 0, 1, 0, K1, {96{1'b1}});
    drive(1, 1, 0, 0, 0, 0);
    chk("R4 loaded all-ones IV", ctr_blk_o, {{96{1'b1}}, 32'd1});
    drive(1, 1, 0, 0, 0, 0);
    chk("R4 IV wraps", ctr_blk_o, {96'd0, 32'd1});
  endtask

  initial begin
    rst_n = 0; load_i = 0; frame_start_i = 0; blk_valid_i = 0; tick_i = 0;
    key_i = 0; iv_i = 0; thresh_i = 32'd3;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_no_key;
    t_stage_commit;
    t_blocks;
    t_frames;
    t_same_cycle_load;
    t_watchdog;
    t_reload;
    t_wrap;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule